// File: doc/BRIEF.md
# Serial-Bus Configuration Register File for a 128-Channel Readout Front End

This block is a two-wire serial (I2C) target that holds the control state of a 128-channel self-triggered readout front end. A bus controller selects the block by its 7-bit address. It sends one pointer byte, then reads or writes registers from that pointer onward. The registers fall into four kinds. Channel-disable masks silence single channels. Bias-adjust bytes feed the analog bias generators. Configuration bytes include the two test enables: one injects charge pulses and one fires the digital trigger path directly. Status bytes are read-only views of an input bus. One more address does not hold a byte. It is the entry point of a 640-bit threshold-trim chain, with 5 bits for each channel.

Each data byte written to the trim address pushes eight bits into the chain. Each byte read from that address pops the eldest eight bits out and feeds them back in at the far end, so a full pass of 80 reads returns the chain to its starting contents. The bus lines are sampled by the system clock, so the block runs in a single clock domain. The only thing it drives onto the bus is an open-drain pull-down enable for SDA.

Top module: `cfg_i2c_regfile`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) only an address byte whose upper seven bits equal `DEV_ADDR`. For any other address it leaves SDA released for the rest of that transfer, and no register changes.
- R2: In a write transfer, the first byte after the address loads the register pointer. Each later byte is written to the register the pointer selects, and the pointer then advances by one. The exception is the trim address 43 (0x2B), where the pointer stays.
- R3: Registers 0 to 15 are the channel masks. Bit k of register r drives `chan_disable_o[8r+k]`, and a 1 disables that channel.
- R4: Registers 16 to 29 are the bias-adjust bytes. Register 16+i drives `adj_o[8i+7:8i]`.
- R5: Registers 30 to 39 are read/write configuration bytes. Register 30+i drives `cfg_o[8i+7:8i]`. In register 30, bit 0 is the test-pulse enable and bit 1 is the test-trigger enable, and they drive `test_pulse_en_o` and `test_trig_en_o`.
- R6: Registers 40 to 42 read back `status_i[7:0]`, `status_i[15:8]` and `status_i[23:16]`. A write to them is acknowledged and advances the pointer, but stores nothing.
- R7: Each byte written at address 43 shifts the trim chain up by eight bits and enters at bits [7:0]. After 80 such bytes, the j-th byte written (counting from 0) sits at `trim_o[639-8j : 632-8j]`.
- R8: Each byte read at address 43 returns `trim_o[639:632]` and rotates the chain up by eight bits, so that byte re-enters at [7:0]. After 80 reads the chain is back to its starting contents.
- R9: In a read transfer, bytes come from the current pointer onward, and the pointer advances after each byte as it does for writes. The transfer ends when the controller does not acknowledge a byte. Addresses 44 and above read as zero and ignore writes.
- R10: While `rst_n` is low at a clock edge, all masks, all configuration bytes (so both test enables), the trim chain and the pointer go to zero, every adjust byte goes to 0x80, and SDA is released.
- R11: The block changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| status_i | input | 24 | Live status bytes for registers 40 to 42 |
| chan_disable_o | output | 128 | Per-channel disable, 1 = channel off |
| adj_o | output | 112 | Fourteen bias-adjust bytes |
| cfg_o | output | 80 | Ten configuration bytes |
| test_pulse_en_o | output | 1 | Charge-injection test mode enable |
| test_trig_en_o | output | 1 | Direct trigger test mode enable |
| trim_o | output | 640 | Threshold-trim chain, 5 bits per channel |

## Verification
Long writes that stream through a whole register group test pointer advance and field placement. Short random writes at random pointers, some landing in the status range, the trim address or unused space, separate stored, ignored and shifted bytes. Reads that follow a repeated start and span all 43 registers compare every readable byte against the model. They also show whether a read at a status address ever disturbs stored state. A full 80-byte trim load, then a full 80-byte read and a partial 3-byte read, separate shift order from rotate order and show whether the chain comes back intact.

// File: rtl/i2c_cfg_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes, register layout and the target state type.
// Assumes channel count is a multiple of 8 and trim length a multiple of 8.
package i2c_cfg_pkg;
    localparam int BYTE_W     = 8;
    localparam int CH_COUNT   = 128;
    localparam int TRIM_BITS  = 5;
    localparam int ADJ_COUNT  = 14;
    localparam int CFG_COUNT  = 10;
    localparam int STAT_COUNT = 3;

    localparam int MASK_COUNT = CH_COUNT / BYTE_W;
    localparam int TRIM_LEN   = CH_COUNT * TRIM_BITS;
    localparam int MASK_BASE  = 0;
    localparam int ADJ_BASE   = MASK_BASE + MASK_COUNT;
    localparam int CFG_BASE   = ADJ_BASE + ADJ_COUNT;
    localparam int STAT_BASE  = CFG_BASE + CFG_COUNT;
    localparam int TRIM_ADDR  = STAT_BASE + STAT_COUNT;
    localparam int REG_COUNT  = TRIM_ADDR + 1;

    localparam logic [BYTE_W-1:0] ADJ_RESET = 8'h80;
    localparam int MODE_IDX   = 0;
    localparam int PULSE_BIT  = 0;
    localparam int TRIG_BIT   = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WR,
        ST_ACK_WR,
        ST_RD,
        ST_RACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain and flags bus events:
// SCL rising/falling edges, START (SDA falls while SCL high) and
// STOP (SDA rises while SCL high).
// Assumes: STAGES >= 2; each SCL phase lasts more than STAGES+2 clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Purpose: synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Purpose: decode line events from current and previous samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_target_fsm.sv
`timescale 1ns/1ps
// Module: i2c_target_fsm
// Byte-level target engine. Matches the address, ACKs, collects write
// bytes (first one tagged as pointer), serializes read bytes and samples
// the controller ACK. Emits one-cycle strobes to the register bank.
// Assumes: rd_data is valid combinationally for the current pointer.
module i2c_target_fsm
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic              wr_is_ptr,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              rd_pop
);
    tgt_state_e        state;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic              got8;
    logic              rd_mode;
    logic              ptr_phase;
    logic              mack;

    // Purpose: bus protocol sequencing, bit shifting and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txsh      <= '0;
            got8      <= 1'b0;
            rd_mode   <= 1'b0;
            ptr_phase <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            wr_stb    <= 1'b0;
            wr_is_ptr <= 1'b0;
            wr_byte   <= '0;
            rd_pop    <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_pop <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                got8   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                got8   <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) got8 <= 1'b1;
                        end else if (scl_fall && got8) begin
                            got8 <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe    <= 1'b1;
                                    rd_mode   <= shreg[0];
                                    ptr_phase <= ~shreg[0];
                                    state     <= ST_ACK_ADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                wr_stb    <= 1'b1;
                                wr_is_ptr <= ptr_phase;
                                wr_byte   <= shreg;
                                ptr_phase <= 1'b0;
                                sda_oe    <= 1'b1;
                                state     <= ST_ACK_WR;
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rd_mode) begin
                                txsh   <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                rd_pop <= 1'b1;
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_ACK_WR: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txsh[BYTE_W-2];
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                txsh   <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                rd_pop <= 1'b1;
                                bitcnt <= '0;
                                state  <= ST_RD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R11
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R1
endmodule

// File: rtl/trim_shift_chain.sv
`timescale 1ns/1ps
// Module: trim_shift_chain
// Long shift register for per-channel threshold trim. A load pushes a
// byte in at the bottom; a rotate moves the top byte to the bottom.
// Assumes: shift_en and rot_en are never both high (bank guarantees).
module trim_shift_chain #(
    parameter int LEN = 640,
    parameter int W   = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           rot_en,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   head,
    output logic [LEN-1:0] vec
);
    // Purpose: chain storage with load-shift and rotate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec <= '0;
        end else if (shift_en) begin
            vec <= {vec[LEN-W-1:0], din};
        end else if (rot_en) begin
            vec <= {vec[LEN-W-1:0], vec[LEN-1 -: W]};
        end
    end

    // Purpose: expose the eldest byte for reads.
    always_comb head = vec[LEN-1 -: W];

    AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_en && !shift_en) |=> ($countones(vec) == $past($countones(vec)))); // R8
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
// Module: cfg_reg_bank
// Register pointer, storage for mask/adjust/config bytes, status view,
// read mux and the trim chain. Pointer advances after each data byte
// except at the trim address, where it stays.
// Assumes: wr_stb and rd_pop are single-cycle and mutually exclusive.
module cfg_reg_bank
    import i2c_cfg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_stb,
    input  logic                           wr_is_ptr,
    input  logic [BYTE_W-1:0]              wr_byte,
    input  logic                           rd_pop,
    input  logic [STAT_COUNT*BYTE_W-1:0]   status_i,
    output logic [BYTE_W-1:0]              rd_data,
    output logic [MASK_COUNT*BYTE_W-1:0]   mask_flat,
    output logic [ADJ_COUNT*BYTE_W-1:0]    adj_flat,
    output logic [CFG_COUNT*BYTE_W-1:0]    cfg_flat,
    output logic [TRIM_LEN-1:0]            trim_vec
);
    localparam logic [BYTE_W-1:0] TRIM_A = BYTE_W'(TRIM_ADDR);
    localparam logic [BYTE_W-1:0] STAT_A = BYTE_W'(STAT_BASE);

    logic [BYTE_W-1:0] ptr_q;
    logic              data_we;
    logic              at_trim;
    logic              in_stat;
    logic [BYTE_W-1:0] trim_head;

    // Purpose: qualify strobes against the current pointer.
    always_comb begin
        data_we = wr_stb & ~wr_is_ptr;
        at_trim = (ptr_q == TRIM_A);
        in_stat = (ptr_q >= STAT_A) && (ptr_q < TRIM_A);
    end

    // Purpose: pointer load and auto-advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_stb && wr_is_ptr) begin
            ptr_q <= wr_byte;
        end else if ((data_we || rd_pop) && !at_trim) begin
            ptr_q <= ptr_q + 8'd1;
        end
    end

    for (genvar i = 0; i < MASK_COUNT; i++) begin : g_mask
        logic [BYTE_W-1:0] q;
        // Purpose: one channel-mask byte.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (data_we && ptr_q == BYTE_W'(MASK_BASE + i)) q <= wr_byte;
        end
        assign mask_flat[i*BYTE_W +: BYTE_W] = q;
    end

    for (genvar i = 0; i < ADJ_COUNT; i++) begin : g_adj
        logic [BYTE_W-1:0] q;
        // Purpose: one bias-adjust byte, mid-scale after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= ADJ_RESET;
            else if (data_we && ptr_q == BYTE_W'(ADJ_BASE + i)) q <= wr_byte;
        end
        assign adj_flat[i*BYTE_W +: BYTE_W] = q;
    end

    for (genvar i = 0; i < CFG_COUNT; i++) begin : g_cfg
        logic [BYTE_W-1:0] q;
        // Purpose: one configuration byte, normal mode after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (data_we && ptr_q == BYTE_W'(CFG_BASE + i)) q <= wr_byte;
        end
        assign cfg_flat[i*BYTE_W +: BYTE_W] = q;
    end

    trim_shift_chain #(
        .LEN (TRIM_LEN),
        .W   (BYTE_W)
    ) trim_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (data_we && at_trim),
        .rot_en   (rd_pop && at_trim),
        .din      (wr_byte),
        .head     (trim_head),
        .vec      (trim_vec)
    );

    // Purpose: read data selection for the current pointer.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < MASK_COUNT; i++)
            if (ptr_q == BYTE_W'(MASK_BASE + i)) rd_data = mask_flat[i*BYTE_W +: BYTE_W];
        for (int i = 0; i < ADJ_COUNT; i++)
            if (ptr_q == BYTE_W'(ADJ_BASE + i)) rd_data = adj_flat[i*BYTE_W +: BYTE_W];
        for (int i = 0; i < CFG_COUNT; i++)
            if (ptr_q == BYTE_W'(CFG_BASE + i)) rd_data = cfg_flat[i*BYTE_W +: BYTE_W];
        for (int i = 0; i < STAT_COUNT; i++)
            if (ptr_q == BYTE_W'(STAT_BASE + i)) rd_data = status_i[i*BYTE_W +: BYTE_W];
        if (at_trim) rd_data = trim_head;
    end

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_is_ptr) |=> (ptr_q == $past(wr_byte))); // R2
    AST_TRIM_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_we || rd_pop) && at_trim) |=> (ptr_q == TRIM_A)); // R7
    AST_STATUS_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && in_stat) |=> ($stable(mask_flat) && $stable(adj_flat)
                                  && $stable(cfg_flat) && $stable(trim_vec))); // R6
endmodule

// File: rtl/cfg_i2c_regfile.sv
`timescale 1ns/1ps
// Module: cfg_i2c_regfile (top)
// Serial-bus configuration register file for a 128-channel front end:
// line synchronizer, byte engine and register bank.
// Assumes: SCL high and low phases each exceed SYNC_STAGES+2 clocks;
// sda_i is the wired-AND bus level including this block's own pull-down.
module cfg_i2c_regfile
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h52,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_oe_o,
    input  logic [STAT_COUNT*BYTE_W-1:0] status_i,
    output logic [CH_COUNT-1:0]          chan_disable_o,
    output logic [ADJ_COUNT*BYTE_W-1:0]  adj_o,
    output logic [CFG_COUNT*BYTE_W-1:0]  cfg_o,
    output logic                         test_pulse_en_o,
    output logic                         test_trig_en_o,
    output logic [TRIM_LEN-1:0]          trim_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb, wr_is_ptr, rd_pop;
    logic [BYTE_W-1:0] wr_byte, rd_data;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm #(
        .DEV_ADDR (DEV_ADDR)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe_o),
        .wr_stb    (wr_stb),
        .wr_is_ptr (wr_is_ptr),
        .wr_byte   (wr_byte),
        .rd_pop    (rd_pop)
    );

    cfg_reg_bank bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_is_ptr (wr_is_ptr),
        .wr_byte   (wr_byte),
        .rd_pop    (rd_pop),
        .status_i  (status_i),
        .rd_data   (rd_data),
        .mask_flat (chan_disable_o),
        .adj_flat  (adj_o),
        .cfg_flat  (cfg_o),
        .trim_vec  (trim_o)
    );

    // Purpose: mode bits taken from the mode configuration byte.
    always_comb begin
        test_pulse_en_o = cfg_o[MODE_IDX*BYTE_W + PULSE_BIT];
        test_trig_en_o  = cfg_o[MODE_IDX*BYTE_W + TRIG_BIT];
    end
endmodule

// File: tb/cfg_i2c_regfile_tb.sv
`timescale 1ns/1ps
// Bench: bus controller tasks, a byte-level model of the register file,
// random and directed transfers, all checks counted locally.
module cfg_i2c_regfile_tb_top;
    import i2c_cfg_pkg::*;

    localparam logic [6:0] DEV = 7'h52;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [23:0] status_v = '0;
    logic        sda_oe_o;
    logic        sda_bus;
    logic [CH_COUNT-1:0]         chan_disable_o;
    logic [ADJ_COUNT*8-1:0]      adj_o;
    logic [CFG_COUNT*8-1:0]      cfg_o;
    logic                        test_pulse_en_o, test_trig_en_o;
    logic [TRIM_LEN-1:0]         trim_o;

    int n_chk = 0;
    int n_err = 0;
    int r11_bad = 0;
    bit done = 0;
    logic oe_prev = 1'b0;

    logic [7:0] wbuf [0:95];
    logic [7:0] m_reg [0:39];
    logic [7:0] m_trim [0:79];
    logic [7:0] m_ptr;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe_o;

    cfg_i2c_regfile dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_bus),
        .sda_oe_o        (sda_oe_o),
        .status_i        (status_v),
        .chan_disable_o  (chan_disable_o),
        .adj_o           (adj_o),
        .cfg_o           (cfg_o),
        .test_pulse_en_o (test_pulse_en_o),
        .test_trig_en_o  (test_trig_en_o),
        .trim_o          (trim_o)
    );

    // R11 monitor: pull-down may only change while SCL is low
    always @(negedge clk) begin
        if (rst_n && (sda_oe_o != oe_prev) && scl_m) r11_bad++;
        oe_prev = sda_oe_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wt(HP/2);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b0; wt(HP);
        scl_m = 1'b0; wt(HP/2);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(HP/2);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b1; wt(HP);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; wt(HP/2);
        scl_m = 1'b1; wt(HP);
        scl_m = 1'b0; wt(HP/2);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; wt(HP/2);
        scl_m = 1'b1; wt(HP/2);
        b = sda_bus; wt(HP/2);
        scl_m = 1'b0; wt(HP/2);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(x);
        ack = ~x;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            rbit(x);
            b[i] = x;
        end
        wbit(give_ack ? 1'b0 : 1'b1);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 40; i++)
            m_reg[i] = (i >= ADJ_BASE && i < CFG_BASE) ? 8'h80 : 8'h00;
        for (int j = 0; j < 80; j++) m_trim[j] = 8'h00;
        m_ptr = 8'd0;
    endtask

    task automatic model_wr(input logic [7:0] b);
        if (m_ptr < 8'd40) m_reg[m_ptr] = b;
        else if (m_ptr == 8'd43) begin
            for (int j = 0; j < 79; j++) m_trim[j] = m_trim[j+1];
            m_trim[79] = b;
        end
        if (m_ptr != 8'd43) m_ptr = m_ptr + 8'd1;
    endtask

    task automatic model_rd(output logic [7:0] e);
        logic [7:0] t;
        if (m_ptr < 8'd40) e = m_reg[m_ptr];
        else if (m_ptr < 8'd43) e = status_v[(m_ptr - 8'd40)*8 +: 8];
        else if (m_ptr == 8'd43) begin
            e = m_trim[0];
            t = m_trim[0];
            for (int j = 0; j < 79; j++) m_trim[j] = m_trim[j+1];
            m_trim[79] = t;
        end else e = 8'h00;
        if (m_ptr != 8'd43) m_ptr = m_ptr + 8'd1;
    endtask

    function automatic logic [TRIM_LEN-1:0] exp_trim();
        logic [TRIM_LEN-1:0] v;
        for (int j = 0; j < 80; j++) v[TRIM_LEN-8-8*j +: 8] = m_trim[j];
        return v;
    endfunction

    task automatic check_ports(input string req);
        logic [127:0] em, ea, ec;
        logic [TRIM_LEN-1:0] et;
        em = '0; ea = '0; ec = '0;
        for (int i = 0; i < 16; i++) em[8*i +: 8] = m_reg[i];
        for (int i = 0; i < 14; i++) ea[8*i +: 8] = m_reg[16+i];
        for (int i = 0; i < 10; i++) ec[8*i +: 8] = m_reg[30+i];
        check(chan_disable_o == em[127:0], req, "chan_disable_o", chan_disable_o, em);
        check(adj_o == ea[111:0], req, "adj_o", 128'(adj_o), ea);
        check(cfg_o == ec[79:0], req, "cfg_o", 128'(cfg_o), ec);
        check({test_trig_en_o, test_pulse_en_o} == m_reg[30][1:0], req, "test enables",
              128'({test_trig_en_o, test_pulse_en_o}), 128'(m_reg[30][1:0]));
        et = exp_trim();
        for (int s = 0; s < 5; s++)
            check(trim_o[128*s +: 128] == et[128*s +: 128], req, "trim_o slice",
                  trim_o[128*s +: 128], et[128*s +: 128]);
    endtask

    task automatic write_txn(input logic [7:0] p, input int n, input string req);
        logic ack;
        bit all_ack;
        i2c_start();
        wbyte({DEV, 1'b0}, ack); all_ack = ack;
        wbyte(p, ack); all_ack &= ack;
        m_ptr = p;
        for (int k = 0; k < n; k++) begin
            wbyte(wbuf[k], ack); all_ack &= ack;
            model_wr(wbuf[k]);
        end
        i2c_stop();
        check(all_ack, req, "write transfer acknowledged", 128'(all_ack), 128'(1));
    endtask

    task automatic read_txn(input logic [7:0] p, input int n, input string req);
        logic ack;
        bit all_ack;
        logic [7:0] b, e;
        int bad;
        logic [7:0] bad_a, bad_e;
        bad = 0; bad_a = '0; bad_e = '0;
        i2c_start();
        wbyte({DEV, 1'b0}, ack); all_ack = ack;
        wbyte(p, ack); all_ack &= ack;
        m_ptr = p;
        i2c_start();
        wbyte({DEV, 1'b1}, ack); all_ack &= ack;
        for (int k = 0; k < n; k++) begin
            rbyte(k < n - 1, b);
            model_rd(e);
            if (b !== e && bad == 0) begin bad_a = b; bad_e = e; end
            if (b !== e) bad++;
        end
        i2c_stop();
        check(all_ack, req, "read transfer acknowledged", 128'(all_ack), 128'(1));
        check(bad == 0, req, "read data", 128'(bad_a), 128'(bad_e));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic ack;
        void'($urandom(32'h5eed_1c2c));
        model_reset();
        status_v = $urandom;
        wt(6);
        rst_n = 1'b1;
        wt(4);

        // R10: reset state
        check(sda_oe_o == 1'b0, "R10", "sda released", 128'(sda_oe_o), 128'(0));
        check_ports("R10");

        // R1: wrong address not acknowledged, nothing stored
        i2c_start();
        wbyte({7'h53, 1'b0}, ack);
        check(!ack, "R1", "foreign address ack", 128'(ack), 128'(0));
        wbyte(8'h00, ack);
        wbyte(8'hFF, ack);
        i2c_stop();
        check(chan_disable_o == '0, "R1", "masks after foreign write", chan_disable_o, 128'(0));

        // R2 R3: stream all mask bytes
        for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom);
        write_txn(8'd0, 16, "R2");
        check_ports("R3");

        // R4: stream all adjust bytes
        for (int k = 0; k < 14; k++) wbuf[k] = 8'($urandom);
        write_txn(8'd16, 14, "R4");
        check_ports("R4");

        // R5: mode bits
        wbuf[0] = 8'h03;
        write_txn(8'd30, 1, "R5");
        check(test_pulse_en_o && test_trig_en_o, "R5", "both test enables",
              128'({test_trig_en_o, test_pulse_en_o}), 128'(3));
        wbuf[0] = 8'h02;
        write_txn(8'd30, 1, "R5");
        check(!test_pulse_en_o && test_trig_en_o, "R5", "trigger only",
              128'({test_trig_en_o, test_pulse_en_o}), 128'(2));
        for (int k = 0; k < 9; k++) wbuf[k] = 8'($urandom);
        write_txn(8'd31, 9, "R5");
        check_ports("R5");

        // R6: status read and ignored writes
        read_txn(8'd40, 3, "R6");
        for (int k = 0; k < 3; k++) wbuf[k] = 8'($urandom);
        write_txn(8'd39, 3, "R6");
        read_txn(8'd39, 3, "R6");
        check_ports("R6");

        // R9: unused addresses
        wbuf[0] = 8'hA5;
        write_txn(8'h30, 1, "R9");
        read_txn(8'h30, 2, "R9");
        check_ports("R9");
        read_txn(8'd0, 43, "R9");

        // R7: full trim load
        for (int k = 0; k < 80; k++) wbuf[k] = 8'($urandom);
        write_txn(8'd43, 80, "R7");
        check_ports("R7");

        // R8: full rotation restores, partial rotation moves
        read_txn(8'd43, 80, "R8");
        check_ports("R8");
        read_txn(8'd43, 3, "R8");
        check_ports("R8");

        // R2: random short writes anywhere, then full readback
        for (int it = 0; it < 24; it++) begin
            int n;
            logic [7:0] p;
            p = 8'($urandom_range(0, 45));
            n = $urandom_range(1, 3);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            write_txn(p, n, "R2");
        end
        check_ports("R2");
        read_txn(8'd0, 43, "R9");
        check_ports("R9");

        // R11: no pull-down change while SCL high
        check(r11_bad == 0, "R11", "sda changes with SCL high", 128'(r11_bad), 128'(0));

        // R10: reset in mid-run
        rst_n = 1'b0;
        wt(4);
        rst_n = 1'b1;
        wt(2);
        model_reset();
        check_ports("R10");
        read_txn(8'd14, 4, "R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule